// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block sits between a dual-modulus prescaler and a phase comparator in a frequency synthesizer. It runs on the prescaler's output clock. A main down-counter spans N prescaler cycles, and a swallow counter inside it holds the prescaler's modulus-control line at the P+1 setting for the first A of those cycles. One comparison pulse therefore marks every P·N+A cycles of the oscillator that feeds the prescaler. A separate counter in the reference-clock domain divides the reference clock by R and produces the reference pulse for the same comparator.

A setting is offered on the `n_set`, `a_set` and `r_set` inputs and taken in while `load` is high. Each clock domain captures only its own fields, on its own rising clock edges. A domain refuses a setting that breaks its range rule and keeps the setting it already holds. A captured setting is used at the next division-period boundary, so a period that is already running always finishes with the values it started with. The prescaler is not part of the block.

Top module: `pulse_swallow_div`

## Requirements
- R1: With a prescaler of low modulus P, consecutive `fp` pulses are separated by exactly P·N+A oscillator cycles.
- R2: `mod_ctl` (1 = divide by P+1, 0 = divide by P) is high in the first A prescaler cycles of each period, starting with the cycle in which `fp` is high. It is low in the remaining N−A cycles. With A = 0 it never goes high.
- R3: `fp` is high for exactly one `clk_pre` cycle, and its rising edges are N `clk_pre` cycles apart.
- R4: `fr` is high for exactly one `clk_ref` cycle, and its rising edges are R `clk_ref` cycles apart.
- R5: While `rst` (synchronous, active high) is held, `fp`, `fr` and `mod_ctl` are 0. After release, the first edge of each clock starts a period with the default settings N = 8, A = 3, R = 12.
- R6: A setting captured part-way through a period leaves that period's length unchanged. It takes effect from the next boundary onward.
- R7: The `clk_pre` domain ignores a load with N < 3 or A ≥ N, and the period stays at its previous length.
- R8: The `clk_ref` domain ignores a load with R < 3, whatever the `clk_pre` domain does with the same load.
- R9: The range limits are honoured: N from 3 to 2047, A from 0 to 127, and R from 3 to 16383.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pre | input | 1 | Prescaler output clock; clocks the main and swallow counters |
| clk_ref | input | 1 | Reference clock; clocks the reference counter |
| rst | input | 1 | Synchronous active-high reset, sampled in both domains |
| load | input | 1 | Capture strobe for the settings, sampled in each domain |
| n_set | input | 11 | Main count N |
| a_set | input | 7 | Swallow count A |
| r_set | input | 14 | Reference ratio R |
| mod_ctl | output | 1 | Prescaler modulus select, 1 = P+1 |
| fp | output | 1 | Divided comparison pulse |
| fr | output | 1 | Divided reference pulse |

## Verification
`fp` and `mod_ctl` are registers, so their values for a prescaler cycle appear right after the `clk_pre` edge that opens that cycle. The prescaler model reads both one oscillator period after that edge, and it picks the length of the cycle from the `mod_ctl` value it reads there. `fr` settles after a `clk_ref` rising edge and is sampled on the following falling edge. A new setting starts at the first boundary after its capture edge. For that reason the bench drops the interval that straddles a load and judges the next full interval. The one exception is the mid-period test, where the straddling interval itself must keep the old length.

// File: rtl/psd_pkg.sv
`timescale 1ns/100ps
package psd_pkg;
    parameter int unsigned N_W     = 11;
    parameter int unsigned A_W     = 7;
    parameter int unsigned R_W     = 14;
    parameter int unsigned DIV_MIN = 3;

    typedef struct packed {
        logic [N_W-1:0] n;
        logic [A_W-1:0] a;
    } main_cfg_t;

    typedef struct packed {
        logic [N_W-1:0] n_left;
        logic [A_W-1:0] a_left;
    } main_cnt_t;

    // a legal main setting: N at least the minimum and A strictly below N
    function automatic logic main_cfg_ok(main_cfg_t c);
        return (c.n >= N_W'(DIV_MIN)) && ({{(N_W-A_W){1'b0}}, c.a} < c.n);
    endfunction

    function automatic logic ref_cfg_ok(logic [R_W-1:0] r);
        return r >= R_W'(DIV_MIN);
    endfunction
endpackage

// File: rtl/psd_cfg_hold.sv
`timescale 1ns/100ps
module psd_cfg_hold #(
    parameter int unsigned W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic         cand_ok,
    input  logic [W-1:0] cand,
    output logic [W-1:0] held
);
    // held value is read by the counter only at its period boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= RST_VAL;
        end else if (capture && cand_ok) begin
            held <= cand;
        end
    end
endmodule

// File: rtl/psd_swallow_ctr.sv
`timescale 1ns/100ps
module psd_swallow_ctr
    import psd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  main_cfg_t cfg,
    output logic      mod_hi,
    output logic      pulse
);
    main_cnt_t cnt_q, cnt_d;
    logic      pulse_q, pulse_d;
    logic      at_end;

    assign at_end = (cnt_q.n_left == N_W'(1));

    always_comb begin
        if (at_end) begin
            cnt_d.n_left = cfg.n;
            cnt_d.a_left = cfg.a;
            pulse_d      = 1'b1;
        end else begin
            cnt_d.n_left = cnt_q.n_left - N_W'(1);
            cnt_d.a_left = (cnt_q.a_left != '0) ? cnt_q.a_left - A_W'(1) : '0;
            pulse_d      = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q.n_left <= N_W'(1);
            cnt_q.a_left <= '0;
            pulse_q      <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            pulse_q <= pulse_d;
        end
    end

    assign mod_hi = (cnt_q.a_left != '0);
    assign pulse  = pulse_q;
endmodule

// File: rtl/psd_ref_ctr.sv
`timescale 1ns/100ps
module psd_ref_ctr
    import psd_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [R_W-1:0] ratio,
    output logic           pulse
);
    logic [R_W-1:0] left_q;
    logic           pulse_q;
    logic           wrap;

    assign wrap = (left_q == R_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q  <= R_W'(1);
            pulse_q <= 1'b0;
        end else if (wrap) begin
            left_q  <= ratio;
            pulse_q <= 1'b1;
        end else begin
            left_q  <= left_q - R_W'(1);
            pulse_q <= 1'b0;
        end
    end

    assign pulse = pulse_q;
endmodule

// File: rtl/pulse_swallow_div.sv
`timescale 1ns/100ps
module pulse_swallow_div
    import psd_pkg::*;
#(
    parameter int unsigned DEF_N = 8,
    parameter int unsigned DEF_A = 3,
    parameter int unsigned DEF_R = 12
) (
    input  logic           clk_pre,
    input  logic           clk_ref,
    input  logic           rst,
    input  logic           load,
    input  logic [N_W-1:0] n_set,
    input  logic [A_W-1:0] a_set,
    input  logic [R_W-1:0] r_set,
    output logic           mod_ctl,
    output logic           fp,
    output logic           fr
);
    localparam int unsigned MAIN_W   = $bits(main_cfg_t);
    localparam main_cfg_t   MAIN_RST = '{n: N_W'(DEF_N), a: A_W'(DEF_A)};
    localparam logic [R_W-1:0] REF_RST = R_W'(DEF_R);

    main_cfg_t      main_cand;
    main_cfg_t      main_cfg;
    logic           main_ok;
    logic [R_W-1:0] ref_cfg;
    logic           ref_ok;

    assign main_cand = '{n: n_set, a: a_set};
    assign main_ok   = main_cfg_ok(main_cand);
    assign ref_ok    = ref_cfg_ok(r_set);

    psd_cfg_hold #(.W(MAIN_W), .RST_VAL(MAIN_RST)) u_main_hold (
        .clk     (clk_pre),
        .rst     (rst),
        .capture (load),
        .cand_ok (main_ok),
        .cand    (main_cand),
        .held    (main_cfg)
    );

    psd_cfg_hold #(.W(R_W), .RST_VAL(REF_RST)) u_ref_hold (
        .clk     (clk_ref),
        .rst     (rst),
        .capture (load),
        .cand_ok (ref_ok),
        .cand    (r_set),
        .held    (ref_cfg)
    );

    psd_swallow_ctr u_main (
        .clk    (clk_pre),
        .rst    (rst),
        .cfg    (main_cfg),
        .mod_hi (mod_ctl),
        .pulse  (fp)
    );

    psd_ref_ctr u_ref (
        .clk   (clk_ref),
        .rst   (rst),
        .ratio (ref_cfg),
        .pulse (fr)
    );
endmodule

// File: rtl/psd_checker.sv
`timescale 1ns/100ps
module psd_checker
    import psd_pkg::*;
(
    input logic clk_pre,
    input logic clk_ref,
    input logic rst,
    input logic mod_ctl,
    input logic fp,
    input logic fr
);
    logic [N_W:0] gap;

    always_ff @(posedge clk_pre) begin
        if (rst || fp) begin
            gap <= '0;
        end else if (!gap[N_W]) begin
            gap <= gap + 1'b1;
        end
    end

    a_r3_fp_single: assert property (@(posedge clk_pre) disable iff (rst)
        fp |=> !fp);

    a_r3_fp_gap_bounded: assert property (@(posedge clk_pre) disable iff (rst)
        !gap[N_W]);

    a_r2_mod_rises_with_fp: assert property (@(posedge clk_pre) disable iff (rst)
        !mod_ctl |=> (!mod_ctl || fp));

    a_r4_fr_single: assert property (@(posedge clk_ref) disable iff (rst)
        fr |=> !fr);

    a_r5_pre_quiet_in_reset: assert property (@(posedge clk_pre)
        $past(rst) |-> (!fp && !mod_ctl));

    a_r5_ref_quiet_in_reset: assert property (@(posedge clk_ref)
        $past(rst) |-> !fr);
endmodule

bind pulse_swallow_div psd_checker u_chk (
    .clk_pre (clk_pre),
    .clk_ref (clk_ref),
    .rst     (rst),
    .mod_ctl (mod_ctl),
    .fp      (fp),
    .fr      (fr)
);

// File: tb/pulse_swallow_div_bench.sv
`timescale 1ns/100ps
module pulse_swallow_div_bench;
    import psd_pkg::*;

    localparam real VCO_T    = 2.0;
    localparam real REF_HALF = 2.5;
    localparam real WD_NS    = 390000.0;
    localparam int unsigned DEF_N = 8, DEF_A = 3, DEF_R = 12;

    typedef struct packed {
        int unsigned p;
        int unsigned n;
        int unsigned a;
        int unsigned r;
    } vec_t;

    localparam int NVEC = 8;
    // R9: first row is the lower limit, last row the upper limits
    localparam vec_t VECS [NVEC] = '{
        '{16,    3,   0,     3},
        '{16,    3,   2,     5},
        '{32,   10,   7,    40},
        '{64,   20,  19,   100},
        '{32,  100,   0,     7},
        '{16,   50,  33,  1000},
        '{64,    5,   4,     3},
        '{16, 2047, 127, 16383}
    };

    logic           clk_pre = 1'b0;
    logic           clk_ref = 1'b0;
    logic           rst     = 1'b1;
    logic           load    = 1'b0;
    logic [N_W-1:0] n_set   = '0;
    logic [A_W-1:0] a_set   = '0;
    logic [R_W-1:0] r_set   = '0;
    logic           mod_ctl, fp, fr;

    pulse_swallow_div u_pulse_swallow_div (
        .clk_pre (clk_pre), .clk_ref (clk_ref), .rst (rst), .load (load),
        .n_set (n_set), .a_set (a_set), .r_set (r_set),
        .mod_ctl (mod_ctl), .fp (fp), .fr (fr)
    );

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    bit          done     = 1'b0;

    // prescaler model and main-period monitor
    int unsigned     pres_p = 16;
    longint unsigned vco_acc = 0, fp_mark = 0;
    int unsigned     last_vco = 0, last_pre = 0, last_mods = 0, fp_evt = 0;
    int unsigned     pre_idx = 0, mods_run = 0;
    bit              last_order_ok = 1'b1, order_ok = 1'b1, seen_low = 1'b0, have_mark = 1'b0;

    initial begin
        forever begin
            int unsigned len;
            clk_pre = 1'b1;
            #(VCO_T);
            len = mod_ctl ? pres_p + 1 : pres_p;
            if (fp) begin
                if (have_mark) begin
                    last_vco      = int'(vco_acc - fp_mark);
                    last_pre      = pre_idx;
                    last_mods     = mods_run;
                    last_order_ok = order_ok;
                    fp_evt++;
                end
                have_mark = 1'b1;
                fp_mark   = vco_acc;
                pre_idx   = 0;
                mods_run  = 0;
                order_ok  = 1'b1;
                seen_low  = 1'b0;
            end
            if (mod_ctl) begin
                mods_run++;
                if (seen_low) order_ok = 1'b0;
            end else begin
                seen_low = 1'b1;
            end
            pre_idx++;
            vco_acc += len;
            #(VCO_T * (len / 2) - VCO_T);
            clk_pre = 1'b0;
            #(VCO_T * (len - len / 2));
        end
    end

    initial begin
        #0.7;
        forever #(REF_HALF) clk_ref = ~clk_ref;
    end

    // reference-period monitor
    int unsigned ref_cnt = 0, last_r = 0, fr_evt = 0;
    bit          r_mark = 1'b0;
    always @(negedge clk_ref) begin
        if (fr) begin
            if (r_mark) begin
                last_r = ref_cnt;
                fr_evt++;
            end
            r_mark  = 1'b1;
            ref_cnt = 1;
        end else begin
            ref_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic apply_cfg(input int unsigned p, input int unsigned n,
                             input int unsigned a, input int unsigned r);
        @(negedge clk_pre);
        #0.5;
        n_set  = N_W'(n);
        a_set  = A_W'(a);
        r_set  = R_W'(r);
        pres_p = p;
        load   = 1'b1;
        @(posedge clk_pre);
        @(posedge clk_ref);
        @(negedge clk_pre);
        #0.5;
        load = 1'b0;
    endtask

    task automatic settle_both();
        int unsigned bp, br;
        bp = fp_evt;
        br = fr_evt;
        fork
            wait (fp_evt == bp + 2);
            wait (fr_evt == br + 2);
        join
    endtask

    task automatic check_main(input string req, input int unsigned p,
                              input int unsigned n, input int unsigned a);
        check(last_vco == p * n + a, req, "oscillator cycles per period", last_vco, p * n + a);
        check(last_pre == n, req, "prescaler cycles per period", last_pre, n);
        check(last_mods == a && last_order_ok, req, "P+1 cycles at period start",
              last_order_ok ? last_mods : 9999, a);
    endtask

    initial begin
        #(WD_NS);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        int unsigned b;
        // R5: quiet outputs while reset is held
        repeat (3) @(posedge clk_pre);
        @(negedge clk_pre);
        #0.5;
        check(fp == 1'b0, "R5", "fp in reset", fp, 0);
        check(mod_ctl == 1'b0, "R5", "mod_ctl in reset", mod_ctl, 0);
        check(fr == 1'b0, "R5", "fr in reset", fr, 0);
        rst = 1'b0;
        // R5: default settings after release
        fork
            wait (fp_evt >= 1);
            wait (fr_evt >= 1);
        join
        check_main("R5", 16, DEF_N, DEF_A);
        check(last_r == DEF_R, "R5", "default reference ratio", last_r, DEF_R);

        // table walk: R1 length, R2 modulus pattern, R3 prescaler count, R4 reference
        for (int i = 0; i < NVEC; i++) begin
            apply_cfg(VECS[i].p, VECS[i].n, VECS[i].a, VECS[i].r);
            settle_both();
            check(last_vco == VECS[i].p * VECS[i].n + VECS[i].a, "R1", "period length",
                  last_vco, VECS[i].p * VECS[i].n + VECS[i].a);
            check(last_mods == VECS[i].a && last_order_ok, "R2", "P+1 cycles at period start",
                  last_order_ok ? last_mods : 9999, VECS[i].a);
            check(last_pre == VECS[i].n, "R3", "fp spacing in prescaler cycles",
                  last_pre, VECS[i].n);
            check(last_r == VECS[i].r, "R4", "fr spacing", last_r, VECS[i].r);
        end

        // R6: a load inside a running period does not change that period
        apply_cfg(16, 100, 5, 9);
        settle_both();
        check_main("R6", 16, 100, 5);
        b = fp_evt;
        wait (fp_evt == b + 1);
        repeat (5) @(negedge clk_pre);
        apply_cfg(16, 20, 3, 9);
        b = fp_evt;
        wait (fp_evt == b + 1);
        check_main("R6", 16, 100, 5);
        wait (fp_evt == b + 2);
        check_main("R6", 16, 20, 3);

        // R7: illegal main settings are ignored
        apply_cfg(16, 2, 0, 9);
        settle_both();
        check_main("R7", 16, 20, 3);
        apply_cfg(16, 10, 10, 9);
        settle_both();
        check_main("R7", 16, 20, 3);

        // R8: illegal R ignored while the main domain accepts its part
        apply_cfg(16, 30, 1, 2);
        settle_both();
        check_main("R8", 16, 30, 1);
        check(last_r == 9, "R8", "reference ratio after rejected R", last_r, 9);

        done = 1'b1;
        finish_run();
    end
endmodule